// File: doc/BRIEF.md
# Processor Power State Controller

This block is a synchronous state machine that follows the low-power state of one processor core. It has five states: Normal, AutoHALT, Stop-Grant, Halt/Grant Snoop and Sleep. It takes the core's halt-executed strobe, the wake-up and initialization pins, the stop-clock, sleep, reset and flush requests, and bus snoop pulses. From these it produces the current state code and an internal clock-run enable. It also emits two one-cycle strobes: one when a flush must be serviced and one when the core must initialize itself.

The pins that can change at any time pass through a chain of `SYNC_STAGES` flops (two by default) before the state machine sees them. The halt, snoop-hit and snoop-done pulses, and the clock-stop configuration bit, are already synchronous to `clk`.

The transitions are named as follows:
- Halt entry: Normal to AutoHALT.
- Wake: AutoHALT to Normal.
- Grant entry: Normal or AutoHALT to Stop-Grant.
- Grant exit: Stop-Grant back to AutoHALT or Normal.
- Snoop entry and snoop exit: between Stop-Grant and Halt/Grant Snoop.
- Sleep entry and sleep exit: between Stop-Grant and Sleep.
- Reset redirect: any state to Normal or Stop-Grant.

When several requests are active at once, the controller applies them in this order, highest first: reset, then bus-init, then stop-clock and sleep, then the interrupt and init wake sources, then flush.

Top module: `pwr_state_ctl`

## Requirements
- R1: After `rst_n` is released, `state` is 0 (Normal), `clk_run` is 1, and neither strobe pulses until a request arrives. The state codes are Normal=0, AutoHALT=1, Stop-Grant=2, Halt/Grant Snoop=3 and Sleep=4.
- R2: A one-cycle `halt_exec` pulse in Normal moves `state` to 1 (AutoHALT).
- R3: In AutoHALT, any of the following moves `state` to 0: `smi_n` low, `init_n` low, `bus_init_n` low, `nmi` high or `intr` high. In Normal these sources leave the state unchanged.
- R4: `stop_clk_n` low in Normal or AutoHALT moves `state` to 2. When it goes high again, the state returns to 1 if Stop-Grant was entered from AutoHALT, and to 0 otherwise.
- R5: A falling edge of `flush_n` in AutoHALT gives exactly one `flush_ack` pulse, and `state` stays at 1. In Stop-Grant a flush request gives no pulse and `state` stays at 2.
- R6: Each falling edge of `core_reset_n` gives exactly one `init_pulse`. While it is held low, `state` goes to 0 from Normal or AutoHALT, and to 2 from Stop-Grant, Halt/Grant Snoop or Sleep.
- R7: While `bus_init_n` is low in Stop-Grant, `state` stays at 2 even if `stop_clk_n` rises. Once bus-init completes, the next grant exit goes to 0, even if Stop-Grant was entered from AutoHALT.
- R8: A `snoop_hit` pulse in Stop-Grant moves `state` to 3. A `snoop_done` pulse there returns it to 2.
- R9: `sleep_n` low in Stop-Grant moves `state` to 4. In Sleep, a rise of `stop_clk_n` is ignored. A rise of `sleep_n` returns the state to 2.
- R10: `clk_run` is 0 exactly when `state` is 2 or 4 and `clk_stop_en` is 1. In every other case it is 1, including in state 3.
- R11: In AutoHALT, stop-clock wins over a simultaneous interrupt and the state goes to 2. An interrupt wins over a simultaneous flush: the state goes to 0 and no `flush_ack` pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller itself |
| halt_exec | input | 1 | One-cycle strobe: the core executed a halt |
| snoop_hit | input | 1 | One-cycle strobe: a bus snoop was detected |
| snoop_done | input | 1 | One-cycle strobe: snoop handling finished |
| clk_stop_en | input | 1 | Configuration bit; 1 lets clocks stop in Stop-Grant and Sleep (power-on value 1) |
| core_reset_n | input | 1 | Core reset request pin, active low, asynchronous |
| bus_init_n | input | 1 | Bus initialization pin, active low, asynchronous |
| stop_clk_n | input | 1 | Stop-clock request pin, active low, asynchronous |
| sleep_n | input | 1 | Sleep request pin, active low, asynchronous |
| smi_n | input | 1 | System management interrupt pin, active low, asynchronous |
| init_n | input | 1 | Soft init pin, active low, asynchronous |
| nmi | input | 1 | Non-maskable interrupt level, active high, asynchronous |
| intr | input | 1 | Maskable interrupt level, active high, asynchronous |
| flush_n | input | 1 | Cache flush request pin, active low, asynchronous |
| state | output | 3 | Current power state code |
| clk_run | output | 1 | Internal clock-run enable |
| flush_ack | output | 1 | One-cycle strobe: service a flush now |
| init_pulse | output | 1 | One-cycle strobe: initialize the core now |

## Verification
The properties take for granted that the asynchronous pins hold each level for at least `SYNC_STAGES` + 1 cycles. They also assume that `halt_exec`, `snoop_hit` and `snoop_done` are single-cycle and synchronous. The properties reason from the synchronized request vector and the stored origin bit, so they never reason about raw pin timing.

The stimulus changes pins only on falling clock edges. It holds every level for several cycles before sampling, and it issues each strobe as a lone one-cycle pulse. This keeps the run within those assumptions.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [2:0] {
        PS_RUN   = 3'd0,
        PS_HALT  = 3'd1,
        PS_GRANT = 3'd2,
        PS_SNOOP = 3'd3,
        PS_SLEEP = 3'd4
    } pwr_state_e;

    // Active-high view of the asynchronous request pins
    typedef struct packed {
        logic rst;
        logic binit;
        logic stp;
        logic slp;
        logic smi;
        logic init;
        logic nmi;
        logic intr;
        logic flush;
    } pin_req_t;

    localparam int PIN_REQ_W = $bits(pin_req_t);

    function automatic logic clocks_may_stop(pwr_state_e s);
        return (s == PS_GRANT) || (s == PS_SLEEP);
    endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d_i;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q_o = chain[STAGES-1];

    initial begin
        if (STAGES < 2) $error("pwr_sync needs at least two stages");
    end

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pin_req_t   req,
    input  logic       halt_exec,
    input  logic       snoop_hit,
    input  logic       snoop_done,
    output pwr_state_e state_q,
    output pwr_state_e state_d,
    output logic       origin_q,
    output logic       act_flush,
    output logic       act_init
);

    logic origin_d;
    logic rst_seen_q;
    logic flush_seen_q;
    logic wake_any;
    logic flush_rise;

    assign wake_any   = req.smi | req.init | req.nmi | req.intr;
    assign flush_rise = req.flush & ~flush_seen_q;

    // Next-state and action decode
    always_comb begin
        state_d   = state_q;
        origin_d  = origin_q;
        act_flush = 1'b0;
        act_init  = req.rst & ~rst_seen_q;

        if (req.rst) begin
            unique case (state_q)
                PS_RUN, PS_HALT: state_d = PS_RUN;
                default:         state_d = PS_GRANT;
            endcase
            origin_d = 1'b0;
        end else begin
            unique case (state_q)
                PS_RUN: begin
                    if (req.stp) begin
                        state_d  = PS_GRANT;
                        origin_d = 1'b0;
                    end else if (halt_exec) begin
                        state_d = PS_HALT;
                    end
                end
                PS_HALT: begin
                    if (req.binit) begin
                        state_d = PS_RUN;
                    end else if (req.stp) begin
                        state_d  = PS_GRANT;
                        origin_d = 1'b1;
                    end else if (wake_any) begin
                        state_d = PS_RUN;
                    end else if (flush_rise) begin
                        act_flush = 1'b1;
                    end
                end
                PS_GRANT: begin
                    if (req.binit) begin
                        origin_d = 1'b0;
                    end else if (!req.stp) begin
                        state_d = origin_q ? PS_HALT : PS_RUN;
                    end else if (req.slp) begin
                        state_d = PS_SLEEP;
                    end else if (snoop_hit) begin
                        state_d = PS_SNOOP;
                    end
                end
                PS_SNOOP: begin
                    if (snoop_done) state_d = PS_GRANT;
                end
                PS_SLEEP: begin
                    if (!req.slp) state_d = PS_GRANT;
                end
                default: state_d = PS_RUN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= PS_RUN;
            origin_q     <= 1'b0;
            rst_seen_q   <= 1'b0;
            flush_seen_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            origin_q     <= origin_d;
            rst_seen_q   <= req.rst;
            flush_seen_q <= req.flush;
        end
    end

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
    import pwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_exec,
    input  logic       snoop_hit,
    input  logic       snoop_done,
    input  logic       clk_stop_en,
    input  logic       core_reset_n,
    input  logic       bus_init_n,
    input  logic       stop_clk_n,
    input  logic       sleep_n,
    input  logic       smi_n,
    input  logic       init_n,
    input  logic       nmi,
    input  logic       intr,
    input  logic       flush_n,
    output logic [2:0] state,
    output logic       clk_run,
    output logic       flush_ack,
    output logic       init_pulse
);

    pin_req_t   req_raw;
    pin_req_t   req_s;
    pwr_state_e state_q;
    pwr_state_e state_d;
    logic       origin_q;
    logic       act_flush;
    logic       act_init;

    always_comb begin
        req_raw.rst   = ~core_reset_n;
        req_raw.binit = ~bus_init_n;
        req_raw.stp   = ~stop_clk_n;
        req_raw.slp   = ~sleep_n;
        req_raw.smi   = ~smi_n;
        req_raw.init  = ~init_n;
        req_raw.nmi   = nmi;
        req_raw.intr  = intr;
        req_raw.flush = ~flush_n;
    end

    pwr_sync #(
        .WIDTH  (PIN_REQ_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL('0)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (req_raw),
        .q_o  (req_s)
    );

    pwr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_s),
        .halt_exec (halt_exec),
        .snoop_hit (snoop_hit),
        .snoop_done(snoop_done),
        .state_q   (state_q),
        .state_d   (state_d),
        .origin_q  (origin_q),
        .act_flush (act_flush),
        .act_init  (act_init)
    );

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_run    <= 1'b1;
            flush_ack  <= 1'b0;
            init_pulse <= 1'b0;
        end else begin
            clk_run    <= ~(clocks_may_stop(state_d) & clk_stop_en);
            flush_ack  <= act_flush;
            init_pulse <= act_init;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk
    import pwr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] state,
    input logic       clk_run,
    input logic       flush_ack,
    input logic       init_pulse,
    input logic       clk_stop_en,
    input logic       halt_exec,
    input pin_req_t   req,
    input logic       origin
);

    p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state <= 3'd4);

    p_halt_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd0 && halt_exec && !req.rst && !req.stp) |=> state == 3'd1);

    p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd1 && !req.rst &&
         (req.binit || (!req.stp && (req.smi || req.init || req.nmi || req.intr))))
        |=> state == 3'd0);

    p_grant_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd2 && !req.rst && !req.binit && !req.stp)
        |=> state == ($past(origin) ? 3'd1 : 3'd0));

    p_flush_only_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ack |-> (state == 3'd1 && $past(state) == 3'd1));

    p_init_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> !init_pulse);

    p_reset_keeps_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req.rst && state == 3'd2) |=> state == 3'd2);

    p_binit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd2 && req.binit) |=> state == 3'd2);

    p_snoop_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd3) |=> (state == 3'd3 || state == 3'd2));

    p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd4 && !req.rst && req.slp) |=> state == 3'd4);

    p_clk_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> clk_run == !((state == 3'd2 || state == 3'd4) && $past(clk_stop_en)));

endmodule

bind pwr_state_ctl pwr_state_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .clk_run    (clk_run),
    .flush_ack  (flush_ack),
    .init_pulse (init_pulse),
    .clk_stop_en(clk_stop_en),
    .halt_exec  (halt_exec),
    .req        (req_s),
    .origin     (origin_q)
);

// File: tb/sim_pwr_state_ctl.sv
module sim_pwr_state_ctl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_exec = 0, snoop_hit = 0, snoop_done = 0, clk_stop_en = 1;
    logic core_reset_n = 1, bus_init_n = 1, stop_clk_n = 1, sleep_n = 1;
    logic smi_n = 1, init_n = 1, nmi = 0, intr = 0, flush_n = 1;
    logic [2:0] state;
    logic clk_run, flush_ack, init_pulse;

    int checks = 0;
    int fails = 0;
    int flush_cnt = 0;
    int init_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwr_state_ctl u0 (
        .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .snoop_hit(snoop_hit),
        .snoop_done(snoop_done), .clk_stop_en(clk_stop_en), .core_reset_n(core_reset_n),
        .bus_init_n(bus_init_n), .stop_clk_n(stop_clk_n), .sleep_n(sleep_n),
        .smi_n(smi_n), .init_n(init_n), .nmi(nmi), .intr(intr), .flush_n(flush_n),
        .state(state), .clk_run(clk_run), .flush_ack(flush_ack), .init_pulse(init_pulse)
    );

    always @(negedge clk) begin
        if (flush_ack === 1'b1) flush_cnt++;
        if (init_pulse === 1'b1) init_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
        #1;
    endtask

    task automatic pulse_halt();
        @(negedge clk); halt_exec = 1;
        @(negedge clk); halt_exec = 0;
        settle();
    endtask

    task automatic go_halt();
        pulse_halt();
        chk("R2 halt entry", state, 1);
    endtask

    task automatic t_reset();
        chk("R1 reset state", state, 0);
        chk("R1 clk_run after reset", clk_run, 1);
        chk("R1 no flush strobe", flush_cnt, 0);
        chk("R1 no init strobe", init_cnt, 0);
    endtask

    task automatic t_wake();
        for (int k = 0; k < 5; k++) begin
            go_halt();
            @(negedge clk);
            case (k)
                0: smi_n = 0;
                1: init_n = 0;
                2: bus_init_n = 0;
                3: nmi = 1;
                default: intr = 1;
            endcase
            settle();
            chk($sformatf("R3 wake source %0d", k), state, 0);
            smi_n = 1; init_n = 1; bus_init_n = 1; nmi = 0; intr = 0;
            settle();
        end
        nmi = 1; settle();
        chk("R3 nmi ignored in Normal", state, 0);
        nmi = 0; settle();
    endtask

    task automatic t_stopclk();
        stop_clk_n = 0; settle();
        chk("R4 grant entry from Normal", state, 2);
        stop_clk_n = 1; settle();
        chk("R4 grant exit to Normal", state, 0);
        go_halt();
        stop_clk_n = 0; settle();
        chk("R4 grant entry from AutoHALT", state, 2);
        stop_clk_n = 1; settle();
        chk("R4 grant exit to AutoHALT", state, 1);
    endtask

    task automatic t_flush();
        int base;
        base = flush_cnt;
        flush_n = 0; settle();
        flush_n = 1; settle();
        chk("R5 one flush_ack in AutoHALT", flush_cnt - base, 1);
        chk("R5 stays AutoHALT", state, 1);
        stop_clk_n = 0; settle();
        base = flush_cnt;
        flush_n = 0; settle();
        flush_n = 1; settle();
        chk("R5 flush ignored in Stop-Grant", flush_cnt - base, 0);
        chk("R5 stays Stop-Grant", state, 2);
        stop_clk_n = 1; settle();
        chk("R4 return to AutoHALT after flush", state, 1);
    endtask

    task automatic t_reset_req();
        int base;
        base = init_cnt;
        core_reset_n = 0; settle();
        chk("R6 reset from AutoHALT gives Normal", state, 0);
        core_reset_n = 1; settle();
        chk("R6 one init_pulse", init_cnt - base, 1);
        stop_clk_n = 0; settle();
        base = init_cnt;
        core_reset_n = 0; settle();
        chk("R6 reset keeps Stop-Grant", state, 2);
        core_reset_n = 1; settle();
        chk("R6 one init_pulse in Stop-Grant", init_cnt - base, 1);
        sleep_n = 0; settle();
        chk("R9 sleep entry", state, 4);
        core_reset_n = 0; settle();
        chk("R6 reset from Sleep gives Stop-Grant", state, 2);
        core_reset_n = 1; sleep_n = 1; stop_clk_n = 1; settle();
        chk("R6 back to Normal", state, 0);
    endtask

    task automatic t_binit();
        go_halt();
        stop_clk_n = 0; settle();
        bus_init_n = 0; settle();
        chk("R7 bus-init holds Stop-Grant", state, 2);
        bus_init_n = 1; settle();
        chk("R7 stays Stop-Grant with stop-clock held", state, 2);
        stop_clk_n = 1; settle();
        chk("R7 exit to Normal after bus-init", state, 0);
        stop_clk_n = 0; settle();
        bus_init_n = 0; settle();
        stop_clk_n = 1; settle();
        chk("R7 bus-init wins over stop-clock release", state, 2);
        bus_init_n = 1; settle();
        chk("R7 completion without stop-clock gives Normal", state, 0);
    endtask

    task automatic t_snoop();
        stop_clk_n = 0; settle();
        @(negedge clk); snoop_hit = 1;
        @(negedge clk); snoop_hit = 0;
        settle();
        chk("R8 snoop entry", state, 3);
        chk("R10 clocks run in snoop", clk_run, 1);
        @(negedge clk); snoop_done = 1;
        @(negedge clk); snoop_done = 0;
        settle();
        chk("R8 snoop exit", state, 2);
    endtask

    task automatic t_sleep();
        sleep_n = 0; settle();
        chk("R9 sleep entry", state, 4);
        chk("R10 clocks stopped in Sleep", clk_run, 0);
        stop_clk_n = 1; settle();
        chk("R9 stop-clock release ignored in Sleep", state, 4);
        stop_clk_n = 0; settle();
        sleep_n = 1; settle();
        chk("R9 sleep exit", state, 2);
    endtask

    task automatic t_gate();
        chk("R10 clocks stopped in Stop-Grant", clk_run, 0);
        clk_stop_en = 0; settle();
        chk("R10 clocks run with enable clear", clk_run, 1);
        clk_stop_en = 1; settle();
        chk("R10 clocks stop again", clk_run, 0);
        stop_clk_n = 1; settle();
        chk("R10 clocks run in Normal", clk_run, 1);
        chk("R4 Normal after gate test", state, 0);
    endtask

    task automatic t_prio();
        int base;
        go_halt();
        @(negedge clk); stop_clk_n = 0; nmi = 1;
        settle();
        chk("R11 stop-clock beats interrupt", state, 2);
        stop_clk_n = 1; nmi = 0; settle();
        chk("R11 back to AutoHALT", state, 1);
        base = flush_cnt;
        @(negedge clk); flush_n = 0; smi_n = 0;
        settle();
        chk("R11 interrupt beats flush", state, 0);
        chk("R11 no flush_ack", flush_cnt - base, 0);
        flush_n = 1; smi_n = 1; settle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        settle();
        t_reset();
        t_wake();
        t_stopclk();
        t_flush();
        t_reset_req();
        t_binit();
        t_snoop();
        t_sleep();
        t_gate();
        t_prio();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule